// File: doc/BRIEF.md
# Bit-band alias access unit

This unit sits between a bus master and a memory port. Two 32 MiB alias windows are decoded on the master side. Each 32-bit word inside a window stands for one bit of a real memory region. A read of an alias word returns that bit as 0 or 1. A write of an alias word sets or clears only that bit, through a read-modify-write on the memory port. Accesses that fall outside both windows go to the memory port unchanged.

The alias offset is the lower 25 address bits. The real byte address is the region base ORed with the offset shifted right by five. The bit number inside the addressed unit comes from the offset shifted right by two, and how many of its bits count depends on the access size. A small sequencer accepts one request at a time. It issues one or two memory transactions and then signals completion with a one-cycle pulse.

Top module: `bitband_unit`

## Requirements
- R1: An address in [0x2200_0000, 0x2400_0000) targets region 0x2000_0000. An address in [0x4200_0000, 0x4400_0000) targets region 0x4000_0000. Any other address is not aliased.
- R2: For an aliased access, the memory address is region base | (address[24:0] >> 5). It has bit 0 cleared for halfword accesses and bits 1:0 cleared for word accesses. `mem_size` equals `bus_size`, with 0 = byte, 1 = halfword and 2 = word.
- R3: The bit index is address[6:2]. Byte accesses use only its low 3 bits, halfword accesses its low 4 bits and word accesses all 5 bits. Lanes are little-endian on the 32-bit data bus. The bit sits at bus position 8*addr[1:0]+index for a byte, 16*addr[1]+index for a halfword, and index for a word.
- R4: An aliased read issues exactly one memory read and no write. `bus_rdata` is 1 when the selected bit is set and 0 otherwise, and bits 31:1 are zero.
- R5: An aliased write issues one memory read and then one memory write, both to the same address and size. The selected bit takes the value of `bus_wdata[0]`, and every other bit of the unit keeps its value.
- R6: Bits 31:1 of `bus_wdata` have no effect on an aliased write.
- R7: A non-aliased access issues one memory transaction with the master's address, size, direction and write data. A read returns `mem_rdata` unchanged.
- R8: `bus_done` is a single-cycle pulse, raised only after the last memory transaction of the request has been acknowledged. `mem_req` stays high with stable address, size and direction until `mem_ack`.
- R9: After synchronous reset the unit is idle, with `bus_done` and `mem_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request, held with its fields until `bus_done` |
| bus_we | input | 1 | 1 = write |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_done | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read result, valid with `bus_done` |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory write |
| mem_size | output | 2 | Memory access size |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data, lane-aligned |
| mem_ack | input | 1 | One-cycle acknowledge of the current transaction |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The assertions assume the memory side pulses `mem_ack` for a single cycle and only while `mem_req` is high. They also assume the master keeps its request fields steady from `bus_req` until `bus_done`. The bench's memory model acknowledges every transaction one cycle after it sees a fresh request and then drops the acknowledge. The master tasks change `bus_req` and its fields only on falling edges, and only before acceptance or after the completion pulse has been seen.

// File: rtl/bb_pkg.sv
package bb_pkg;

    parameter int BB_AW    = 32;
    parameter int BB_DW    = 32;
    localparam int BB_POS_W = $clog2(BB_DW);
    localparam int BB_ALIAS_SHIFT = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } bb_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_RESP
    } bb_state_e;

    typedef struct packed {
        logic                hit;
        logic [BB_AW-1:0]    addr;
        logic [BB_POS_W-1:0] pos;
    } bb_target_t;

    typedef struct packed {
        logic                hit;
        logic                we;
        bb_size_e            size;
        logic [BB_AW-1:0]    addr;
        logic [BB_POS_W-1:0] pos;
        logic                set;
        logic [BB_DW-1:0]    wdata;
    } bb_req_t;

    function automatic logic [BB_AW-1:0] bb_align(input bb_size_e sz, input logic [BB_AW-1:0] a);
        case (sz)
            SZ_BYTE: return a;
            SZ_HALF: return {a[BB_AW-1:1], 1'b0};
            default: return {a[BB_AW-1:2], 2'b00};
        endcase
    endfunction

    function automatic logic [BB_POS_W-1:0] bb_bus_pos(input bb_size_e sz, input logic [1:0] lane,
                                                       input logic [4:0] idx);
        case (sz)
            SZ_BYTE: return BB_POS_W'({lane, idx[2:0]});
            SZ_HALF: return BB_POS_W'({lane[1], idx[3:0]});
            default: return BB_POS_W'(idx);
        endcase
    endfunction

endpackage

// File: rtl/bb_window_match.sv
module bb_window_match
    import bb_pkg::*;
#(
    parameter logic [BB_AW-1:0] ALIAS_BASE  = 32'h2200_0000,
    parameter logic [BB_AW-1:0] REGION_BASE = 32'h2000_0000,
    parameter int               WIN_BITS    = 25
) (
    input  logic [BB_AW-1:0] addr,
    output logic             hit,
    output logic [BB_AW-1:0] tgt
);
    localparam int HI_W = BB_AW - WIN_BITS;

    logic [BB_AW-1:0] offset;

    assign hit    = (addr[BB_AW-1:WIN_BITS] == ALIAS_BASE[BB_AW-1:WIN_BITS]);
    assign offset = {{HI_W{1'b0}}, addr[WIN_BITS-1:0]};
    assign tgt    = REGION_BASE | (offset >> BB_ALIAS_SHIFT);
endmodule

// File: rtl/bb_decode.sv
module bb_decode
    import bb_pkg::*;
#(
    parameter int                          NUM_WIN      = 2,
    parameter int                          WIN_BITS     = 25,
    parameter logic [NUM_WIN-1:0][BB_AW-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN-1:0][BB_AW-1:0] REGION_BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [BB_AW-1:0] addr,
    input  bb_size_e         size,
    output bb_target_t       target
);
    logic [NUM_WIN-1:0]            hits;
    logic [NUM_WIN-1:0][BB_AW-1:0] tgts;
    logic [BB_AW-1:0]              raw;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        bb_window_match #(
            .ALIAS_BASE (ALIAS_BASES[g]),
            .REGION_BASE(REGION_BASES[g]),
            .WIN_BITS   (WIN_BITS)
        ) i_match (
            .addr(addr),
            .hit (hits[g]),
            .tgt (tgts[g])
        );
    end

    always_comb begin
        raw = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (hits[i]) raw = raw | tgts[i];
        end
        target.hit  = |hits;
        target.addr = target.hit ? bb_align(size, raw) : addr;
        target.pos  = bb_bus_pos(size, raw[1:0], addr[6:2]);
    end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
    import bb_pkg::*;
(
    input  logic [BB_DW-1:0]    word,
    input  logic [BB_POS_W-1:0] pos,
    input  logic                set,
    output logic [BB_DW-1:0]    merged,
    output logic                bit_val
);
    for (genvar g = 0; g < BB_DW; g++) begin : g_bit
        assign merged[g] = (pos == BB_POS_W'(g)) ? set : word[g];
    end

    assign bit_val = word[pos];
endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
    import bb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_req,
    input  logic                bus_we,
    input  bb_size_e            bus_size,
    input  logic [BB_DW-1:0]    bus_wdata,
    input  bb_target_t          target,
    output logic                bus_done,
    output logic [BB_DW-1:0]    bus_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output bb_size_e            mem_size,
    output logic [BB_AW-1:0]    mem_addr,
    output logic [BB_DW-1:0]    mem_wdata,
    input  logic                mem_ack,
    input  logic [BB_DW-1:0]    mem_rdata,
    input  logic [BB_DW-1:0]    merged,
    input  logic                bit_val,
    output logic [BB_POS_W-1:0] cur_pos,
    output logic                cur_set,
    output logic                alias_hit_q,
    output logic                wr_q
);
    bb_state_e        state;
    bb_req_t          req_q;
    logic [BB_DW-1:0] rdata_q;
    logic [BB_DW-1:0] wb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            req_q   <= '0;
            rdata_q <= '0;
            wb_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (bus_req) begin
                        req_q.hit   <= target.hit;
                        req_q.we    <= bus_we;
                        req_q.size  <= bus_size;
                        req_q.addr  <= target.addr;
                        req_q.pos   <= target.pos;
                        req_q.set   <= bus_wdata[0];
                        req_q.wdata <= bus_wdata;
                        state       <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (mem_ack) begin
                        if (req_q.we)       rdata_q <= '0;
                        else if (req_q.hit) rdata_q <= {{(BB_DW-1){1'b0}}, bit_val};
                        else                rdata_q <= mem_rdata;
                        wb_q  <= merged;
                        state <= (req_q.hit && req_q.we) ? ST_WR : ST_RESP;
                    end
                end
                ST_WR: begin
                    if (mem_ack) state <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req     = (state == ST_RD) || (state == ST_WR);
    assign mem_we      = (state == ST_WR) || ((state == ST_RD) && !req_q.hit && req_q.we);
    assign mem_size    = req_q.size;
    assign mem_addr    = req_q.addr;
    assign mem_wdata   = (state == ST_WR) ? wb_q : req_q.wdata;
    assign bus_done    = (state == ST_RESP);
    assign bus_rdata   = rdata_q;
    assign cur_pos     = req_q.pos;
    assign cur_set     = req_q.set;
    assign alias_hit_q = req_q.hit;
    assign wr_q        = req_q.we;
endmodule

// File: rtl/bitband_unit.sv
module bitband_unit
    import bb_pkg::*;
#(
    parameter int                            NUM_WIN      = 2,
    parameter int                            WIN_BITS     = 25,
    parameter logic [NUM_WIN-1:0][BB_AW-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN-1:0][BB_AW-1:0] REGION_BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [1:0]       bus_size,
    input  logic [BB_AW-1:0] bus_addr,
    input  logic [BB_DW-1:0] bus_wdata,
    output logic             bus_done,
    output logic [BB_DW-1:0] bus_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [1:0]       mem_size,
    output logic [BB_AW-1:0] mem_addr,
    output logic [BB_DW-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [BB_DW-1:0] mem_rdata
);
    bb_size_e            size_in;
    bb_size_e            size_out;
    bb_target_t          target;
    logic [BB_DW-1:0]    merged;
    logic                bit_val;
    logic [BB_POS_W-1:0] cur_pos;
    logic                cur_set;
    logic                alias_hit_q;
    logic                wr_q;

    assign size_in  = bb_size_e'(bus_size);
    assign mem_size = size_out;

    bb_decode #(
        .NUM_WIN     (NUM_WIN),
        .WIN_BITS    (WIN_BITS),
        .ALIAS_BASES (ALIAS_BASES),
        .REGION_BASES(REGION_BASES)
    ) i_decode (
        .addr  (bus_addr),
        .size  (size_in),
        .target(target)
    );

    bb_bit_merge i_merge (
        .word   (mem_rdata),
        .pos    (cur_pos),
        .set    (cur_set),
        .merged (merged),
        .bit_val(bit_val)
    );

    bb_ctrl i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_size   (size_in),
        .bus_wdata  (bus_wdata),
        .target     (target),
        .bus_done   (bus_done),
        .bus_rdata  (bus_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_size   (size_out),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .merged     (merged),
        .bit_val    (bit_val),
        .cur_pos    (cur_pos),
        .cur_set    (cur_set),
        .alias_hit_q(alias_hit_q),
        .wr_q       (wr_q)
    );
endmodule

// File: rtl/bb_checker.sv
module bb_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_done,
    input logic [31:0] bus_rdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [1:0]  mem_size,
    input logic        alias_hit_q,
    input logic        wr_q
);
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        bus_done |=> !bus_done);

    a_r8_done_after_mem: assert property (@(posedge clk) disable iff (rst)
        bus_done |-> !mem_req);

    a_r8_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));

    a_r4_single_bit: assert property (@(posedge clk) disable iff (rst)
        (bus_done && alias_hit_q && !wr_q) |-> (bus_rdata[31:1] == 31'd0));

    a_r5_writeback_same: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !mem_we && alias_hit_q && wr_q)
        |=> (mem_req && mem_we && $stable(mem_addr) && $stable(mem_size)));

    a_r4_no_alias_read_write: assert property (@(posedge clk) disable iff (rst)
        (mem_req && alias_hit_q && !wr_q) |-> !mem_we);
endmodule

bind bitband_unit bb_checker i_bb_checker (
    .clk        (clk),
    .rst        (rst),
    .bus_done   (bus_done),
    .bus_rdata  (bus_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .alias_hit_q(alias_hit_q),
    .wr_q       (wr_q)
);

// File: tb/test_bitband_unit.sv
module test_bitband_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_done;
    logic [31:0] bus_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    int total = 0;
    int bad = 0;
    int n_rd;
    int n_wr;
    logic [31:0] last_addr;
    logic [1:0]  last_size;
    logic [31:0] mem [0:511];

    always #5 clk = ~clk;

    bitband_unit i_bitband_unit (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic int midx(input logic [31:0] a);
        return int'({a[30], a[9:2]});
    endfunction

    function automatic logic [3:0] lanes(input logic [31:0] a, input logic [1:0] sz);
        case (sz)
            2'd0:    return 4'b0001 << a[1:0];
            2'd1:    return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // behavioural RAM, one-cycle acknowledge
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            n_rd      <= 0;
            n_wr      <= 0;
            last_addr <= '0;
            last_size <= '0;
            for (int i = 0; i < 512; i++) mem[i] <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            last_addr <= mem_addr;
            last_size <= mem_size;
            if (mem_we) begin
                for (int l = 0; l < 4; l++)
                    if (lanes(mem_addr, mem_size)[l]) mem[midx(mem_addr)][l*8 +: 8] <= mem_wdata[l*8 +: 8];
                n_wr <= n_wr + 1;
            end else begin
                mem_rdata <= mem[midx(mem_addr)];
                n_rd      <= n_rd + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input logic we, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd);
        int cnt;
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!bus_done && cnt < 50);
        if (!bus_done) chk("R8 access timeout", 32'd0, 32'd1);
        rd = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic test_reset();
        chk("R9 bus_done after reset", {31'd0, bus_done}, 32'd0);
        chk("R9 mem_req after reset", {31'd0, mem_req}, 32'd0);
    endtask

    // sweep every bit of one unit through its alias words
    task automatic test_bits(input logic [31:0] abase, input logic [31:0] rbase,
                             input logic [31:0] t, input logic [1:0] sz);
        int nb;
        logic [31:0] rd;
        nb = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        for (int b = 0; b < nb; b++) begin
            int pos;
            int r0;
            int w0;
            logic [31:0] pat;
            logic [31:0] al;
            logic [31:0] msk;
            pos = (sz == 2'd0) ? int'(t[1:0]) * 8 + b : (sz == 2'd1) ? int'(t[1]) * 16 + b : b;
            msk = 32'd1 << pos;
            pat = 32'h5A3C_C3A5 ^ (32'(b) * 32'h0101_0101);
            al  = abase + (t - rbase) * 32 + 32'(b) * 4;
            access({t[31:2], 2'b00}, 1'b1, 2'd2, pat, rd);
            r0 = n_rd; w0 = n_wr;
            access(al, 1'b0, sz, 32'hFFFF_FFFF, rd);
            chk("R4 alias read value", rd, {31'd0, pat[pos]});
            chk("R4 alias read one access", 32'(n_rd - r0) + 32'(n_wr - w0) * 16, 32'd1);
            chk("R2 alias target address", last_addr, t);
            chk("R2 alias size", {30'd0, last_size}, {30'd0, sz});
            r0 = n_rd; w0 = n_wr;
            access(al, 1'b1, sz, (b % 2 == 0) ? 32'h0000_0001 : 32'hFFFF_FFFF, rd);
            chk("R5 set preserves others", mem[midx(t)], pat | msk);
            chk("R5 rmw counts", 32'(n_rd - r0) + 32'(n_wr - w0) * 16, 32'd17);
            access(al, 1'b0, sz, 32'h0, rd);
            chk("R3 read after set", rd, 32'd1);
            access(al, 1'b1, sz, (b % 2 == 0) ? 32'hFFFF_FFFE : 32'h0, rd);
            chk("R6 clear ignores upper bits", mem[midx(t)], pat & ~msk);
            access(al, 1'b0, sz, 32'h0, rd);
            chk("R3 read after clear", rd, 32'd0);
        end
    endtask

    task automatic test_pass();
        logic [31:0] rd;
        int w0;
        access(32'h2000_03FC, 1'b1, 2'd2, 32'h1122_3344, rd);
        chk("R7 word write through", mem[255], 32'h1122_3344);
        w0 = n_wr;
        access(32'h21FF_FFFD, 1'b1, 2'd0, 32'h0000_AB00, rd);
        chk("R1 below window byte write", mem[255], 32'h1122_AB44);
        chk("R7 address unchanged", last_addr, 32'h21FF_FFFD);
        chk("R7 one write", 32'(n_wr - w0), 32'd1);
        access(32'h2000_0000, 1'b1, 2'd2, 32'hCAFE_F00D, rd);
        access(32'h2400_0000, 1'b0, 2'd2, 32'h0, rd);
        chk("R1 above window raw read", rd, 32'hCAFE_F00D);
        chk("R7 read address unchanged", last_addr, 32'h2400_0000);
        access(32'h4400_0000, 1'b0, 2'd1, 32'h0, rd);
        chk("R1 above second window", last_addr, 32'h4400_0000);
    endtask

    task automatic test_done_pulse();
        logic [31:0] rd;
        access(32'h2200_0000, 1'b0, 2'd2, 32'h0, rd);
        @(negedge clk);
        chk("R8 done one cycle", {31'd0, bus_done}, 32'd0);
        chk("R8 idle after done", {31'd0, mem_req}, 32'd0);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_bits(32'h2200_0000, 32'h2000_0000, 32'h2000_0041, 2'd0);
        test_bits(32'h4200_0000, 32'h4000_0000, 32'h4000_0083, 2'd0);
        test_bits(32'h2200_0000, 32'h2000_0000, 32'h2000_0102, 2'd1);
        test_bits(32'h4200_0000, 32'h4000_0000, 32'h4000_0020, 2'd1);
        test_bits(32'h2200_0000, 32'h2000_0000, 32'h2000_01F0, 2'd2);
        test_bits(32'h4200_0000, 32'h4000_0000, 32'h4000_0300, 2'd2);
        test_pass();
        test_done_pulse();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule